// File: doc/BRIEF.md
# Strobed Parallel Register Bus Slave

This block is a register-access slave for a slow parallel bus. The bus uses one set of lines for both address and data, and the host drives it with strobes that are not related to the local clock. The local clock runs much faster than the bus, so every strobe phase lasts many local cycles. The block passes the address-latch strobe and the active-low read and write strobes through a flip-flop synchronizer chain. It then finds their edges in the local domain and runs each bus access through a small state machine.

The data lines are never synchronized. The block samples them directly, at a local edge chosen by the synchronized strobes. When the address strobe ends, the shared lines are taken as the address. A later read strobe puts the selected register on the output lines and turns on the output enable. A later write strobe stores the lines when it ends. The bank holds sixteen implemented registers in a 256-entry address space.

Top module: `abus_slave`

## Requirements
- R1: While reset is held and on the first cycle after it, `bus_oe` is 0 and `bus_out` is 0x00. All sixteen registers reset to 0x00.
- R2: The block takes the address from `bus_in` at the local edge where the synchronized `ale` is first seen low after being high. Addresses 0x00 to 0x0F select the implemented registers.
- R3: The block writes `bus_in` into the addressed register at the local edge where the synchronized `wr_n` is first seen high after a write began. This is the third rising edge of `clk` after `wr_n` rises between edges, so the data must stay valid for at least three clock periods after the rise.
- R4: After `rd_n` falls between clock edges, `bus_oe` is still 0 after the second rising edge of `clk`. It is 1 after the third, and `bus_out` then holds the addressed register.
- R5: After `rd_n` rises between clock edges, `bus_oe` is still 1 after the second rising edge of `clk` and is 0 after the third. This is one local cycle after the synchronized strobe is seen high.
- R6: A read at any address from 0x10 to 0xFF returns 0x00 with `bus_oe` asserted. A write to such an address changes no implemented register, including the one that shares its low four bits.
- R7: Read and write strobes that arrive before the first address strobe since reset do nothing. `bus_oe` stays 0 and no register changes.
- R8: If `rd_n` and `wr_n` are both low at the same time, nothing is written and `bus_oe` stays 0. After both go high, the next normal access works.
- R9: `bus_oe` is 1 only while the host holds `rd_n` low, or within two local edges after `rd_n` rises. Whenever `bus_oe` is 0, `bus_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock, much faster than the bus strobes |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Asynchronous address-latch strobe, active high |
| rd_n | input | 1 | Asynchronous read strobe, active low |
| wr_n | input | 1 | Asynchronous write strobe, active low |
| bus_in | input | 8 | Shared address/data lines from the host |
| bus_out | output | 8 | Read data driven toward the host |
| bus_oe | output | 1 | Output enable for the shared lines |

## Verification
The bench goes after the latency of the synchronizer chain. A design with too few stages, or one that acts on the raw strobes, turns the output enable on or off one or more cycles early, and the edge-exact read test catches this. It also strobes reads and writes before any address strobe. A design that does not track that an address has been taken drives the bus, or writes whatever address it reset to, and register 0 comes back changed. Writes go to an address above the implemented range whose low bits alias a real register. A design that decodes only the low bits overwrites that register. Finally, the bench overlaps the read and write strobes. A design that does not abort either stores the data or enables its drivers while the host is writing, and the per-cycle model reports the enable or the corrupted register.

// File: rtl/abus_pkg.sv
package abus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_ABORT = 2'd3
  } bus_state_t;

  // Bit positions of the strobes inside the synchronized bundle
  localparam int STB_ALE = 2;
  localparam int STB_RD  = 1;
  localparam int STB_WR  = 0;
  localparam int STB_W   = 3;

endpackage

// File: rtl/abus_sync_edge.sv
module abus_sync_edge #(
  parameter int          WIDTH     = 3,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_q,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  generate
    if (STAGES < 2) begin : g_bad_depth
      $error("abus_sync_edge needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RESET_VAL;
    else     stage_q[0] <= async_in;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RESET_VAL;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RESET_VAL;
    else     prev_q <= stage_q[STAGES-1];
  end

  assign sync_q = stage_q[STAGES-1];
  assign fall   = prev_q & ~sync_q;

endmodule

// File: rtl/abus_fsm.sv
module abus_fsm
  import abus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic addr_valid,
  input  logic rd_s,
  input  logic wr_s,
  input  logic rd_fall,
  input  logic wr_fall,
  output logic read_next,
  output logic reg_we
);

  bus_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    reg_we  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (addr_valid && !rd_s && !wr_s) state_d = ST_ABORT;
        else if (addr_valid && rd_fall)    state_d = ST_READ;
        else if (addr_valid && wr_fall)    state_d = ST_WRITE;
      end
      ST_READ: begin
        if (!wr_s)     state_d = ST_ABORT;
        else if (rd_s) state_d = ST_IDLE;
      end
      ST_WRITE: begin
        if (!rd_s) begin
          state_d = ST_ABORT;
        end else if (wr_s) begin
          reg_we  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_ABORT: begin
        if (rd_s && wr_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign read_next = (state_d == ST_READ);

  // R8
  abort_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ABORT && !(rd_s && wr_s)) |=> !reg_we && !read_next);

endmodule

// File: rtl/abus_regbank.sv
module abus_regbank #(
  parameter int DATA_W = 8,
  parameter int NREGS  = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/abus_slave.sv
module abus_slave
  import abus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int NREGS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);

  localparam int IDX_W = $clog2(NREGS);
  localparam logic [STB_W-1:0] STB_IDLE = 3'b011;
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = ADDR_W'(NREGS);

  logic [STB_W-1:0] stb_raw, stb_s, stb_fall;
  logic ale_s, rd_s, wr_s, ale_fall, rd_fall, wr_fall;

  assign stb_raw[STB_ALE] = ale;
  assign stb_raw[STB_RD]  = rd_n;
  assign stb_raw[STB_WR]  = wr_n;

  abus_sync_edge #(
    .WIDTH     (STB_W),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (STB_IDLE)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (stb_raw),
    .sync_q   (stb_s),
    .fall     (stb_fall)
  );

  assign ale_s    = stb_s[STB_ALE];
  assign rd_s     = stb_s[STB_RD];
  assign wr_s     = stb_s[STB_WR];
  assign ale_fall = stb_fall[STB_ALE];
  assign rd_fall  = stb_fall[STB_RD];
  assign wr_fall  = stb_fall[STB_WR];

  // Address latch: the shared lines are sampled raw, qualified by the strobe
  logic [ADDR_W-1:0] addr_q;
  logic              addr_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      addr_valid <= 1'b0;
    end else if (ale_fall) begin
      addr_q     <= ADDR_W'(bus_in);
      addr_valid <= 1'b1;
    end
  end

  logic addr_hit;
  assign addr_hit = (addr_q < ADDR_LIMIT);

  logic read_next, reg_we;

  abus_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .addr_valid (addr_valid),
    .rd_s       (rd_s),
    .wr_s       (wr_s),
    .rd_fall    (rd_fall),
    .wr_fall    (wr_fall),
    .read_next  (read_next),
    .reg_we     (reg_we)
  );

  logic [DATA_W-1:0] bank_rdata;
  logic              bank_we;

  assign bank_we = reg_we && addr_hit;

  abus_regbank #(
    .DATA_W (DATA_W),
    .NREGS  (NREGS)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (bank_we),
    .idx   (addr_q[IDX_W-1:0]),
    .wdata (bus_in),
    .rdata (bank_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe  <= 1'b0;
      bus_out <= '0;
    end else begin
      bus_oe  <= read_next;
      bus_out <= (read_next && addr_hit) ? bank_rdata : '0;
    end
  end

  // R9
  oe_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (!rd_s || !$past(rd_s)));

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_s) |=> !bus_oe);

  // R7
  we_needs_addr_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> addr_valid);

  // R8
  we_single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (rd_s && wr_s));

  // R2
  ale_capture_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ale_s) |=> addr_valid);

endmodule

// File: tb/tb_abus_slave.sv
`timescale 1ns/1ps
module tb_abus_slave;

  localparam int MD_IDLE = 0, MD_RD = 1, MD_WR = 2, MD_AB = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;

  abus_slave dut (
    .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // Reference model state
  int h_ale[3], h_rd[3], h_wr[3];
  int mode, maddr, mvalid;
  int mregs[16];
  int exp_oe, exp_out, allow_oe;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin h_ale[i] = 0; h_rd[i] = 1; h_wr[i] = 1; end
      for (int i = 0; i < 16; i++) mregs[i] = 0;
      mode = MD_IDLE; maddr = 0; mvalid = 0;
      exp_oe = 0; exp_out = 0; allow_oe = 0;
    end else begin
      int nxt, we, sr, pr, sw, pw, sa, pa;
      sa = h_ale[1]; pa = h_ale[2];
      sr = h_rd[1];  pr = h_rd[2];
      sw = h_wr[1];  pw = h_wr[2];
      nxt = mode; we = 0;
      case (mode)
        MD_IDLE: begin
          if (mvalid && !sr && !sw) nxt = MD_AB;
          else if (mvalid && pr && !sr) nxt = MD_RD;
          else if (mvalid && pw && !sw) nxt = MD_WR;
        end
        MD_RD: if (!sw) nxt = MD_AB; else if (sr) nxt = MD_IDLE;
        MD_WR: if (!sr) nxt = MD_AB; else if (sw) begin we = 1; nxt = MD_IDLE; end
        default: if (sr && sw) nxt = MD_IDLE;
      endcase
      if (we && maddr < 16) mregs[maddr] = int'(bus_in);
      exp_oe  = (nxt == MD_RD) ? 1 : 0;
      exp_out = (exp_oe != 0 && maddr < 16) ? mregs[maddr] : 0;
      if (pa && !sa) begin maddr = int'(bus_in); mvalid = 1; end
      mode = nxt;
      for (int i = 2; i > 0; i--) begin
        h_ale[i] = h_ale[i-1]; h_rd[i] = h_rd[i-1]; h_wr[i] = h_wr[i-1];
      end
      h_ale[0] = int'(ale); h_rd[0] = int'(rd_n); h_wr[0] = int'(wr_n);
      allow_oe = (h_rd[0] == 0 || h_rd[1] == 0 || h_rd[2] == 0) ? 1 : 0;
    end
  end

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      n_chk++;
      if (int'(bus_oe) != exp_oe || int'(bus_out) != exp_out) begin
        n_fail++;
        $display("FAIL R4 R9 model: actual oe=%0d out=%02h expected oe=%0d out=%02h",
                 bus_oe, bus_out, exp_oe, exp_out);
      end
      n_chk++;
      if (bus_oe && allow_oe == 0) begin
        n_fail++;
        $display("FAIL R9 window: actual oe=1 expected oe=0");
      end
      if (!bus_oe && bus_out != 8'h00) begin
        n_fail++;
        $display("FAIL R9 idle data: actual %02h expected 00", bus_out);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic int rw();
    return int'($urandom_range(9, 4));
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_addr(logic [7:0] a);
    bus_in = a; wait_n(rw());
    ale = 1'b1; wait_n(rw());
    ale = 1'b0; wait_n(rw());
    bus_in = 8'($urandom); wait_n(rw());
  endtask

  task automatic host_write(logic [7:0] d);
    bus_in = d; wait_n(rw());
    wr_n = 1'b0; wait_n(rw());
    wr_n = 1'b1; wait_n(rw());
    bus_in = 8'($urandom); wait_n(rw());
  endtask

  task automatic host_read(output int got, output int oe);
    rd_n = 1'b0; wait_n(rw());
    got = int'(bus_out); oe = int'(bus_oe);
    rd_n = 1'b1; wait_n(rw());
  endtask

  int expv[16];
  int got, oe;

  initial begin
    wait_n(5);
    // R1 reset state
    check("R1 oe in reset", int'(bus_oe), 0);
    check("R1 out in reset", int'(bus_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe after reset", int'(bus_oe), 0);
    check("R1 out after reset", int'(bus_out), 0);

    // R7: strobes with no address strobe since reset
    host_read(got, oe);
    check("R7 read without address oe", oe, 0);
    host_write(8'hA5);
    host_addr(8'h00);
    host_read(got, oe);
    check("R7 reg0 untouched", got, 0);

    // R2 R3: write every implemented register, then read back
    for (int i = 0; i < 16; i++) begin
      expv[i] = (i * 37 + 91) & 8'hFF;
      host_addr(8'(i));
      host_write(8'(expv[i]));
    end
    for (int i = 15; i >= 0; i--) begin
      host_addr(8'(i));
      host_read(got, oe);
      check("R2 readback oe", oe, 1);
      check("R3 readback data", got, expv[i]);
    end

    // R4 R5: edge-exact enable timing
    host_addr(8'h05);
    rd_n = 1'b0;
    wait_n(2); check("R4 oe after 2nd edge", int'(bus_oe), 0);
    wait_n(1); check("R4 oe after 3rd edge", int'(bus_oe), 1);
    check("R4 data", int'(bus_out), expv[5]);
    wait_n(2);
    rd_n = 1'b1;
    wait_n(2); check("R5 oe after 2nd edge", int'(bus_oe), 1);
    wait_n(1); check("R5 oe after 3rd edge", int'(bus_oe), 0);
    wait_n(4);

    // R6: unimplemented addresses
    host_addr(8'h13);
    host_write(8'hEE);
    host_read(got, oe);
    check("R6 high read oe", oe, 1);
    check("R6 high read data", got, 0);
    host_addr(8'hFF);
    host_write(8'h77);
    host_read(got, oe);
    check("R6 top read data", got, 0);
    host_addr(8'h03);
    host_read(got, oe);
    check("R6 alias reg3 unchanged", got, expv[3]);
    host_addr(8'h0F);
    host_read(got, oe);
    check("R6 alias reg15 unchanged", got, expv[15]);

    // R8: overlapping strobes
    host_addr(8'h07);
    bus_in = 8'h3C; wait_n(5);
    wr_n = 1'b0; wait_n(6);
    rd_n = 1'b0; wait_n(6);
    check("R8 oe while both low", int'(bus_oe), 0);
    wr_n = 1'b1; wait_n(6);
    rd_n = 1'b1; wait_n(6);
    host_addr(8'h07);
    host_read(got, oe);
    check("R8 reg7 unchanged", got, expv[7]);
    host_addr(8'h07);
    host_write(8'h81);
    host_read(got, oe);
    check("R8 write after abort", got, 8'h81);

    wait_n(10);
    summary();
    $finish;
  end

endmodule